// File: doc/BRIEF.md
# Folded Soft-Decision Viterbi Decoder (K=7, Rate 1/2)

This block recovers the information bits of a rate-1/2 convolutional code with constraint length 7 (64 trellis states, generators 133 and 171 octal, free distance 10). Each trellis step it takes a pair of 4-bit soft symbols and emits one hard decision. Decisions come out of a register-exchange survivor memory of fixed depth, so every output bit refers to the step `DEPTH` steps back.

The compile-time parameter `FOLD` (1, 2, 4 or 8) sets how many clocks the add-compare-select work of one step occupies. The butterfly array holds `32/FOLD` butterflies. Path metrics and survivors sit in a bank that rotates by one window each sub-step, so the butterflies always read the same fixed slice and need no phase-indexed select on the metric read. At `FOLD=1` the decoder accepts one symbol pair and emits one bit every clock.

The decoder is reset once at start-up and then runs back-to-back frames. The symbol pair of the sixth tail bit of each frame carries `in_last`. At that step the decoder re-anchors to the all-zero state and flushes the pending decisions of the finished frame along the zero-state path. Gaps in the input stream freeze all trellis state.

Top module: `vit_fold_dec`

## Requirements
- R1: With generators 133/171 octal, an encoder starting in state 0, and window bit 6 the current input and bit 0 the oldest, clean input decodes exactly. The output stream is `DEPTH` zero bits followed by every encoded bit, tail zeros included, in order, one output per accepted symbol pair.
- R2: Soft symbols are offset binary: 0 is a confident zero and 15 a confident one. The branch metric is the summed per-symbol distance. A fully inverted symbol every 11 steps or more, among weak symbols (values 3 and 12), is still corrected.
- R3: After a symbol pair is accepted, `in_ready` stays low for `FOLD-1` clocks. With a free output and a continuous input, accepts are exactly `FOLD` clocks apart.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` does not change.
- R5: Cycles without an input transfer change no trellis state. Each accepted pair yields exactly one output, with no loss or duplication across idle gaps.
- R6: A pair marked with `in_last` re-anchors the decoder to state 0, and the pending bits of that frame are resolved along the zero-state path. Consecutive frames then decode with no reset between them.
- R7: Path metrics are modular and unsigned. Their spread stays below half the metric range, so decoding stays correct over arbitrarily long runs.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1, and the first `DEPTH` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Symbol pair present |
| in_ready | output | 1 | Decoder can take a symbol pair |
| in_sym0 | input | 4 | Soft value of the first code symbol (from generator 133) |
| in_sym1 | input | 4 | Soft value of the second code symbol (from generator 171) |
| in_last | input | 1 | Pair belongs to the final tail bit of a frame |
| out_valid | output | 1 | Decoded bit present |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded bit |

## Verification
A corrupted path metric or survivor does not show up at once. A wrong survivor bit reaches `out_bit` about `DEPTH` steps later. A metric that wraps or a wrongly chosen ACS decision shows up as burst errors on the stream at that same delay. A lost or repeated step shifts every following bit, so the scoreboard sees an unbroken run of mismatches. A failed re-anchor corrupts the last bits of a frame and the start of the next one. For these reasons the bench compares every output bit, runs long noisy and multi-frame streams, and checks the exact number of bits left in the pipeline at the end.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int NS   = 64;
  localparam int HALF = NS / 2;
  localparam int SW   = 4;
  localparam int BM_W = SW + 1;
  localparam int PM_W = 10;
  localparam logic [6:0] GEN_A = 7'b1011011;
  localparam logic [6:0] GEN_B = 7'b1111001;

  typedef logic [PM_W-1:0] pm_t;

  function automatic logic [1:0] code_bits(input logic b, input logic [5:0] st);
    logic [6:0] w;
    w = {b, st};
    return {^(w & GEN_A), ^(w & GEN_B)};
  endfunction

  function automatic logic mod_less(input pm_t a, input pm_t b);
    pm_t d;
    d = a - b;
    return d[PM_W-1];
  endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu
  import vit_pkg::*;
(
  input  logic [SW-1:0]             sym0,
  input  logic [SW-1:0]             sym1,
  output logic [3:0][BM_W-1:0]      bm
);
  for (genvar c = 0; c < 4; c++) begin : g_code
    logic [SW-1:0] d0, d1;
    assign d0 = ((c / 2) == 1) ? ~sym0 : sym0;
    assign d1 = ((c % 2) == 1) ? ~sym1 : sym1;
    assign bm[c] = BM_W'(d0) + BM_W'(d1);
  end
endmodule

// File: rtl/vit_acs.sv
module vit_acs
  import vit_pkg::*;
#(
  parameter int NB    = 16,
  parameter int DEPTH = 48,
  parameter int PHW   = 1
) (
  input  logic [PHW-1:0]              ph,
  input  logic [2*NB-1:0][PM_W-1:0]   om_w,
  input  logic [2*NB-1:0][DEPTH-1:0]  op_w,
  input  logic [3:0][BM_W-1:0]        bm,
  output logic [NB-1:0][PM_W-1:0]     nm_lo,
  output logic [NB-1:0][PM_W-1:0]     nm_hi,
  output logic [NB-1:0][DEPTH-1:0]    np_lo,
  output logic [NB-1:0][DEPTH-1:0]    np_hi
);
  for (genvar i = 0; i < NB; i++) begin : g_bf
    logic [4:0] j;
    logic [5:0] p0, p1;
    assign j  = 5'(32'(ph) * NB + i);
    assign p0 = {j, 1'b0};
    assign p1 = {j, 1'b1};
    for (genvar b = 0; b < 2; b++) begin : g_tgt
      pm_t m0, m1, mw;
      logic pick;
      logic [DEPTH-1:0] pw;
      assign m0   = om_w[2*i]   + pm_t'(bm[code_bits(1'(b), p0)]);
      assign m1   = om_w[2*i+1] + pm_t'(bm[code_bits(1'(b), p1)]);
      assign pick = mod_less(m1, m0);
      assign mw   = pick ? m1 : m0;
      assign pw   = {pick ? op_w[2*i+1][DEPTH-2:0] : op_w[2*i][DEPTH-2:0], 1'(b)};
      if (b == 0) begin : g_lo
        assign nm_lo[i] = mw;
        assign np_lo[i] = pw;
      end else begin : g_hi
        assign nm_hi[i] = mw;
        assign np_hi[i] = pw;
      end
    end
  end
endmodule

// File: rtl/vit_best.sv
module vit_best
  import vit_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NS-1:0][PM_W-1:0] m,
  output logic [5:0]              idx
);
  logic spread_ok;

  always_comb begin
    idx = '0;
    for (int s = 1; s < NS; s++)
      if (mod_less(m[s], m[idx])) idx = 6'(s);
  end

  always_comb begin
    pm_t d;
    spread_ok = 1'b1;
    for (int s = 0; s < NS; s++) begin
      d = m[s] - m[idx];
      if (d[PM_W-1]) spread_ok = 1'b0;
    end
  end

  // R7: metric spread never approaches the modular wrap point
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst) spread_ok);
endmodule

// File: rtl/vit_fold_dec.sv
module vit_fold_dec
  import vit_pkg::*;
#(
  parameter int FOLD  = 2,
  parameter int DEPTH = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_sym0,
  input  logic [SW-1:0] in_sym1,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit
);
  localparam int  NB  = HALF / FOLD;
  localparam int  WIN = 2 * NB;
  localparam int  PHW = (FOLD > 1) ? $clog2(FOLD) : 1;
  localparam pm_t PEN = pm_t'(1) << (PM_W - 3);

  logic [NS-1:0][PM_W-1:0]    om;
  logic [NS-1:0][DEPTH-1:0]   op;
  logic [HALF-1:0][PM_W-1:0]  nlo_m, nhi_m, lo_m, hi_m;
  logic [HALF-1:0][DEPTH-1:0] nlo_p, nhi_p, lo_p, hi_p;
  logic [NB-1:0][PM_W-1:0]    acs_lo_m, acs_hi_m;
  logic [NB-1:0][DEPTH-1:0]   acs_lo_p, acs_hi_p;
  logic [3:0][BM_W-1:0]       bm;
  logic [PHW-1:0]             ph;
  logic [SW-1:0]              h0, h1, c0, c1;
  logic                       hlast, hbit, cur_last, dec_bit, in_fire, run, last_ph;
  logic [5:0]                 best_idx;

  assign in_ready = (ph == '0) && (!out_valid || out_ready);
  assign in_fire  = in_valid && in_ready;
  assign run      = in_fire || (ph != '0);
  assign last_ph  = (ph == PHW'(FOLD - 1));
  assign c0       = (ph == '0) ? in_sym0 : h0;
  assign c1       = (ph == '0) ? in_sym1 : h1;
  assign cur_last = (ph == '0) ? in_last : hlast;
  assign dec_bit  = (ph == '0) ? op[best_idx][DEPTH-1] : hbit;

  vit_bmu u_bmu (.sym0(c0), .sym1(c1), .bm(bm));

  vit_acs #(.NB(NB), .DEPTH(DEPTH), .PHW(PHW)) u_acs (
    .ph(ph), .om_w(om[WIN-1:0]), .op_w(op[WIN-1:0]), .bm(bm),
    .nm_lo(acs_lo_m), .nm_hi(acs_hi_m), .np_lo(acs_lo_p), .np_hi(acs_hi_p)
  );

  vit_best u_best (.clk(clk), .rst(rst), .m(om), .idx(best_idx));

  // shift the fresh results of this sub-step into the new-metric banks
  always_comb begin
    for (int s = 0; s < HALF; s++) begin
      if (s < HALF - NB) begin
        lo_m[s] = nlo_m[(s + NB) % HALF];
        hi_m[s] = nhi_m[(s + NB) % HALF];
        lo_p[s] = nlo_p[(s + NB) % HALF];
        hi_p[s] = nhi_p[(s + NB) % HALF];
      end else begin
        lo_m[s] = acs_lo_m[((s + NB) % HALF) % NB];
        hi_m[s] = acs_hi_m[((s + NB) % HALF) % NB];
        lo_p[s] = acs_lo_p[((s + NB) % HALF) % NB];
        hi_p[s] = acs_hi_p[((s + NB) % HALF) % NB];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      h0        <= '0;
      h1        <= '0;
      hlast     <= 1'b0;
      hbit      <= 1'b0;
      nlo_m     <= '0;
      nhi_m     <= '0;
      nlo_p     <= '0;
      nhi_p     <= '0;
      op        <= '0;
      for (int s = 0; s < NS; s++) om[s] <= (s == 0) ? pm_t'(0) : PEN;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (in_fire) begin
        h0    <= in_sym0;
        h1    <= in_sym1;
        hlast <= in_last;
        hbit  <= op[best_idx][DEPTH-1];
      end
      if (run) begin
        nlo_m <= lo_m;
        nhi_m <= hi_m;
        nlo_p <= lo_p;
        nhi_p <= hi_p;
        if (last_ph) begin
          ph        <= '0;
          out_valid <= 1'b1;
          out_bit   <= dec_bit;
          for (int s = 0; s < HALF; s++) begin
            if (cur_last) begin
              om[s]        <= (s == 0) ? pm_t'(0) : PEN;
              om[s + HALF] <= PEN;
              op[s]        <= lo_p[0];
              op[s + HALF] <= lo_p[0];
            end else begin
              om[s]        <= lo_m[s];
              om[s + HALF] <= hi_m[s];
              op[s]        <= lo_p[s];
              op[s + HALF] <= hi_p[s];
            end
          end
        end else begin
          ph <= ph + PHW'(1);
          for (int s = 0; s < NS; s++) begin
            om[s] <= om[(s + WIN) % NS];
            op[s] <= op[(s + WIN) % NS];
          end
        end
      end
    end
  end

  // R4: a pending decision is held until taken
  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  // R5: no input transfer and no step in flight leaves the trellis frozen
  a_r5_idle_freeze: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(om) && $stable(op));

  // R6: after a tail step the zero state is the best state
  a_r6_anchor: assert property (@(posedge clk) disable iff (rst)
    run && last_ph && cur_last |=> best_idx == 6'd0);

  if (FOLD > 1) begin : g_fold_chk
    // R3: a folded step blocks new input while it runs
    a_r3_fold_busy: assert property (@(posedge clk) disable iff (rst)
      in_fire |=> !in_ready);
  end
endmodule

// File: tb/vit_fold_dec_test.sv
module vit_fold_dec_test;
  localparam int FOLD  = 2;
  localparam int DEPTH = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [3:0] in_sym0 = '0, in_sym1 = '0;
  logic in_ready, out_valid, out_bit;

  always #4 clk = ~clk;

  vit_fold_dec #(.FOLD(FOLD), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym0(in_sym0), .in_sym1(in_sym1), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  int checks = 0, fails = 0, cyc = 0, n_acc = 0, n_out = 0, last_acc = -1;
  bit rate_mode = 0, bp_en = 0, done = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [5:0] enc = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // driver: encode one bit, push the expectation, hand the pair over
  task automatic send_bit(input bit b, input bit last, input bit [1:0] flip,
                          input bit clean, input string tag);
    logic [6:0] w;
    logic [3:0] s0, s1;
    w  = {b, enc};
    s0 = (^(w & 7'b1011011)) ? (clean ? 4'd15 : 4'd12) : (clean ? 4'd0 : 4'd3);
    s1 = (^(w & 7'b1111001)) ? (clean ? 4'd15 : 4'd12) : (clean ? 4'd0 : 4'd3);
    if (flip[1]) s0 = ~s0;
    if (flip[0]) s1 = ~s1;
    enc = {b, enc[5:1]};
    exp_q.push_back(b);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b1; in_sym0 = s0; in_sym1 = s1; in_last = last;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    n_acc++;
    if (rate_mode && last_acc >= 0)
      chk(cyc - last_acc == FOLD, "R3 accept spacing", cyc - last_acc, FOLD);
    last_acc = cyc;
  endtask

  task automatic send_frame(input int nbits, input int nper, input int gap,
                            input bit clean, input string tag);
    for (int i = 0; i < nbits; i++) begin
      bit [1:0] fl;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fl = 2'b00;
      if (nper > 0 && (i % nper) == nper / 2) fl = ((i / nper) % 2 == 0) ? 2'b10 : 2'b01;
      send_bit(lfsr[0], 1'b0, fl, clean, tag);
      if (gap > 0 && (i % 17) == 16) repeat (gap) @(negedge clk);
    end
    for (int t = 0; t < 6; t++) send_bit(1'b0, t == 5, 2'b00, clean, tag);
  endtask

  // monitor: scoreboard pop/compare plus hold check
  initial begin
    int mcnt = 0;
    bit hold_pend = 0;
    logic held = 1'b0;
    forever begin
      @(negedge clk);
      mcnt++;
      out_ready = !bp_en || (mcnt % 3 != 0);
      #1;
      if (!rst) begin
        if (hold_pend) begin
          chk(out_valid === 1'b1 && out_bit === held, "R4 hold", int'(out_bit), int'(held));
          hold_pend = 0;
        end
        if (out_valid && out_ready) begin
          n_out++;
          if (exp_q.size() == 0) chk(0, "R5 extra output", n_out, n_acc);
          else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_bit === e, t, int'(out_bit), int'(e));
          end
        end else if (out_valid && !out_ready) begin
          hold_pend = 1;
          held = out_bit;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin exp_q.push_back(1'b0); tag_q.push_back("R8 startup zeros"); end
    #2;
    chk(out_valid === 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R8 in_ready after reset", int'(in_ready), 1);

    rate_mode = 1;
    send_frame(40, 0, 0, 1'b1, "R1 clean frame");
    rate_mode = 0;

    bp_en = 1;
    send_frame(60, 11, 0, 1'b0, "R2 noisy frame R4 backpressure");
    bp_en = 0;

    repeat (12) @(negedge clk);
    chk(n_out == n_acc, "R5 one output per step", n_out, n_acc);
    repeat (30) @(negedge clk);
    #2;
    chk(n_out == n_acc && out_valid === 1'b0, "R5 idle no output", n_out, n_acc);

    for (int f = 0; f < 30; f++)
      send_frame(30 + f * 3, 9 + (f % 4), (f % 3 == 0) ? 5 : 0, 1'b0, "R6 back-to-back frames");

    send_frame(2000, 13, 0, 1'b0, "R7 long run");
    send_frame(DEPTH, 0, 0, 1'b1, "R1 flush frame");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == DEPTH, "R1 latency depth", exp_q.size(), DEPTH);
    chk(n_out == n_acc, "R5 final count", n_out, n_acc);
    report();
  end
endmodule